// File: doc/BRIEF.md
# Two-Digit Decimal Counter with Segment Drive

This block is a decimal event counter that runs from 00 to 99 and drives two seven-segment digits directly, one for the units and one for the tens. Each digit is held as a 4-bit BCD value. Each digit has its own decoder that produces an active-low segment pattern and blanks the digit when the code is not a decimal digit. A flag output is high whenever the counter shows 00. Software and board-level concerns are not part of this block, so the controls arrive already clean and the clock arrives already at the counting rate.

Three controls set the behaviour, and their priority is fixed.

- **Clear (`MODE_CLEAR`).** An active-low clear zeroes both digits at once, without waiting for a clock edge.
- **Preset load (`MODE_LOAD`).** An active-low load copies the preset BCD inputs into the digits at once. While the load stays low, the digits follow the preset again on every rising clock edge.
- **Hold (`MODE_HOLD`).** When neither clear nor load is active and run is low, a rising edge keeps the value unchanged.
- **Count (`MODE_COUNT`).** When neither clear nor load is active and run is high, each rising edge adds one.

The mode is decoded again from the controls in every cycle. The transitions are:

- Any mode goes to `MODE_CLEAR` when clear falls.
- `MODE_CLEAR` goes to `MODE_LOAD` when clear rises while load is low.
- `MODE_CLEAR` goes to `MODE_HOLD` or `MODE_COUNT` when clear rises while load is high.
- `MODE_LOAD` goes to `MODE_HOLD` or `MODE_COUNT` when load rises.
- `MODE_HOLD` and `MODE_COUNT` swap when run changes.

Top module: `dec_counter_2d`

## Requirements
- R1: Segment outputs are active low, seven bits per digit, with segment a in bit 6 and g in bit 0. Digits 0 to 9 give 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000, 0000100. The units digit occupies seg_n_o[6:0] and the tens digit occupies seg_n_o[13:7].
- R2: While clr_n_i is low, both digits are 0 and the display reads 00. This takes effect without a clock edge and overrides load and run.
- R3: A falling edge on ld_n_i with clr_n_i high loads preset_bcd_i at once. The units code is bits 3:0 and the tens code is bits 7:4. While ld_n_i stays low, every rising clock edge reloads the preset and no counting occurs.
- R4: With clear and load inactive and run_i low, a rising clock edge leaves the value unchanged.
- R5: With clear and load inactive and run_i high, each rising clock edge adds one. A units digit of 9 returns to 0 and advances the tens digit.
- R6: From 99, the next counting edge gives 00.
- R7: A digit code from 10 to 15 drives all seven segments of that digit high (1111111).
- R8: A preset code above 9 is loaded unchanged. On the counting edge that advances that digit, it becomes 0 and generates no carry into the next digit.
- R9: zero_o is high exactly when the displayed value is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| clr_n_i | input | 1 | Asynchronous clear, active low |
| ld_n_i | input | 1 | Asynchronous preset load, active low |
| run_i | input | 1 | 1 = count, 0 = hold |
| preset_bcd_i | input | 8 | Preset codes, tens in [7:4], units in [3:0] |
| seg_n_o | output | 14 | Active-low segments, tens in [13:7], units in [6:0] |
| zero_o | output | 1 | High when the display reads 00 |

## Verification
The decoder is driven through the preset load with all sixteen 4-bit codes placed in both digits. This separates the ten valid patterns from one another and confirms that codes 10 to 15 blank the digit. A run of 100 consecutive counting edges from 00 checks each step against a model value, which distinguishes a units rollover from a tens carry and confirms the return from 99 to 00. The directed cases that follow cover several behaviours:

- holding with run low;
- a preset that changes while the load is held;
- clear applied together with load;
- illegal preset codes in either digit, which separate a clamp without carry from a clamp that happens on a carry.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int unsigned BCD_W = 4;
    localparam int unsigned SEG_W = 7;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_HOLD  = 2'd2,
        MODE_COUNT = 2'd3
    } dcnt_mode_e;

    localparam logic [SEG_W-1:0] SEG_BLANK = 7'b1111111;
    localparam logic [SEG_W-1:0] SEG_ZERO  = 7'b0000001;

endpackage

// File: rtl/dcnt_bcd_digit.sv
module dcnt_bcd_digit
    import dcnt_pkg::*;
(
    input  logic             clk_i,
    input  logic             clr_n_i,
    input  logic             ld_n_i,
    input  logic [BCD_W-1:0] preset_i,
    input  logic             step_i,
    output logic [BCD_W-1:0] digit_o,
    output logic             at_nine_o
);

    localparam logic [BCD_W-1:0] LAST = BCD_W'(9);

    logic [BCD_W-1:0] digit_q;

    always_ff @(posedge clk_i or negedge clr_n_i or negedge ld_n_i) begin
        if (!clr_n_i) begin
            digit_q <= '0;
        end else if (!ld_n_i) begin
            digit_q <= preset_i;
        end else if (step_i) begin
            if (digit_q >= LAST) begin
                digit_q <= '0;
            end else begin
                digit_q <= digit_q + BCD_W'(1);
            end
        end
    end

    assign digit_o   = digit_q;
    assign at_nine_o = (digit_q == LAST);

endmodule

// File: rtl/dcnt_seg_decode.sv
module dcnt_seg_decode
    import dcnt_pkg::*;
(
    input  logic [BCD_W-1:0] code_i,
    output logic [SEG_W-1:0] seg_n_o
);

    always_comb begin
        unique case (code_i)
            4'd0:    seg_n_o = 7'b0000001;
            4'd1:    seg_n_o = 7'b1001111;
            4'd2:    seg_n_o = 7'b0010010;
            4'd3:    seg_n_o = 7'b0000110;
            4'd4:    seg_n_o = 7'b1001100;
            4'd5:    seg_n_o = 7'b0100100;
            4'd6:    seg_n_o = 7'b0100000;
            4'd7:    seg_n_o = 7'b0001111;
            4'd8:    seg_n_o = 7'b0000000;
            4'd9:    seg_n_o = 7'b0000100;
            default: seg_n_o = SEG_BLANK;
        endcase
    end

endmodule

// File: rtl/dec_counter_2d.sv
module dec_counter_2d
    import dcnt_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned CODE_W = DIGITS * BCD_W,
    localparam int unsigned DISP_W = DIGITS * SEG_W
) (
    input  logic              clk_i,
    input  logic              clr_n_i,
    input  logic              ld_n_i,
    input  logic              run_i,
    input  logic [CODE_W-1:0] preset_bcd_i,
    output logic [DISP_W-1:0] seg_n_o,
    output logic              zero_o
);

    dcnt_mode_e        mode;
    logic [CODE_W-1:0] digit_q;
    logic [DIGITS-1:0] at_nine;
    logic [DIGITS:0]   step_chain;
    logic [DIGITS-1:0] is_zero;

    always_comb begin
        unique case ({clr_n_i, ld_n_i, run_i})
            3'b000, 3'b001, 3'b010, 3'b011: mode = MODE_CLEAR;
            3'b100, 3'b101:                 mode = MODE_LOAD;
            3'b110:                         mode = MODE_HOLD;
            default:                        mode = MODE_COUNT;
        endcase
    end

    assign step_chain[0] = (mode == MODE_COUNT);

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        dcnt_bcd_digit u_digit (
            .clk_i     (clk_i),
            .clr_n_i   (clr_n_i),
            .ld_n_i    (ld_n_i),
            .preset_i  (preset_bcd_i[d*BCD_W +: BCD_W]),
            .step_i    (step_chain[d]),
            .digit_o   (digit_q[d*BCD_W +: BCD_W]),
            .at_nine_o (at_nine[d])
        );

        assign step_chain[d+1] = step_chain[d] & at_nine[d];
        assign is_zero[d]      = (digit_q[d*BCD_W +: BCD_W] == '0);

        dcnt_seg_decode u_dec (
            .code_i  (digit_q[d*BCD_W +: BCD_W]),
            .seg_n_o (seg_n_o[d*SEG_W +: SEG_W])
        );
    end

    assign zero_o = &is_zero;

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker
    import dcnt_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned CODE_W = DIGITS * BCD_W,
    localparam int unsigned DISP_W = DIGITS * SEG_W
) (
    input logic              clk_i,
    input logic              clr_n_i,
    input logic              ld_n_i,
    input logic              run_i,
    input logic [CODE_W-1:0] preset_bcd_i,
    input logic [CODE_W-1:0] digit_q,
    input logic [DISP_W-1:0] seg_n_o,
    input logic              zero_o
);

    int   cur_val;
    logic cur_ok;
    int   max_val;

    always_comb begin
        cur_val = 0;
        cur_ok  = 1'b1;
        max_val = 0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            cur_val = cur_val * 10 + int'(digit_q[i*BCD_W +: BCD_W]);
            max_val = max_val * 10 + 9;
            if (digit_q[i*BCD_W +: BCD_W] > 4'd9) cur_ok = 1'b0;
        end
    end

    AST_CLEAR_SHOWS_ZERO: assert property (@(posedge clk_i)
        !clr_n_i |-> (seg_n_o == {DIGITS{SEG_ZERO}})); // R2

    AST_LOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (!ld_n_i && $past(!ld_n_i && clr_n_i) && $stable(preset_bcd_i))
            |-> (digit_q == preset_bcd_i)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (ld_n_i && $past(ld_n_i && clr_n_i && !run_i)) |-> $stable(digit_q)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (ld_n_i && $past(ld_n_i && clr_n_i && run_i) && $past(cur_ok))
            |-> (cur_val == (($past(cur_val) == max_val) ? 0 : $past(cur_val) + 1))); // R5 R6

    AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        zero_o == (seg_n_o == {DIGITS{SEG_ZERO}})); // R9

    for (genvar d = 0; d < DIGITS; d++) begin : g_blank
        AST_BLANK_INVALID: assert property (@(posedge clk_i) disable iff (!clr_n_i)
            (digit_q[d*BCD_W +: BCD_W] > 4'd9)
                |-> (seg_n_o[d*SEG_W +: SEG_W] == SEG_BLANK)); // R7
    end

endmodule

bind dec_counter_2d dcnt_checker #(.DIGITS(DIGITS)) u_dcnt_checker (
    .clk_i        (clk_i),
    .clr_n_i      (clr_n_i),
    .ld_n_i       (ld_n_i),
    .run_i        (run_i),
    .preset_bcd_i (preset_bcd_i),
    .digit_q      (digit_q),
    .seg_n_o      (seg_n_o),
    .zero_o       (zero_o)
);

// File: tb/dec_counter_2d_bench.sv
module dec_counter_2d_bench;

    localparam int CLK_HALF = 2;

    localparam logic [6:0] PAT [16] = '{
        7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110,
        7'b1001100, 7'b0100100, 7'b0100000, 7'b0001111,
        7'b0000000, 7'b0000100, 7'b1111111, 7'b1111111,
        7'b1111111, 7'b1111111, 7'b1111111, 7'b1111111
    };

    logic        clk_i = 1'b0;
    logic        clr_n_i;
    logic        ld_n_i;
    logic        run_i;
    logic [7:0]  preset_bcd_i;
    logic [13:0] seg_n_o;
    logic        zero_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_HALF) clk_i = ~clk_i;

    dec_counter_2d u_dec_counter_2d (
        .clk_i        (clk_i),
        .clr_n_i      (clr_n_i),
        .ld_n_i       (ld_n_i),
        .run_i        (run_i),
        .preset_bcd_i (preset_bcd_i),
        .seg_n_o      (seg_n_o),
        .zero_o       (zero_o)
    );

    function automatic logic [13:0] disp(input int tens, input int units);
        return {PAT[tens], PAT[units]};
    endfunction

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_zero(input string req, input logic exp);
        checks++;
        if (zero_o !== exp) begin
            errors++;
            $display("FAIL %s: zero_o actual %b expected %b", req, zero_o, exp);
        end
    endtask

    task automatic edge_settle();
        @(posedge clk_i);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk_i);
    endtask

    task automatic load_value(input logic [7:0] val);
        at_neg();
        preset_bcd_i = val;
        ld_n_i       = 1'b0;
        #1;
        at_neg();
        ld_n_i = 1'b1;
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clr_n_i      = 1'b0;
        ld_n_i       = 1'b1;
        run_i        = 1'b0;
        preset_bcd_i = 8'h00;
        #1;
        check("R2 reset state", seg_n_o, disp(0, 0));
        check_zero("R9 reset state", 1'b1);
        repeat (3) at_neg();
        clr_n_i = 1'b1;

        // Table walk: every 4-bit code in both digits (R1, R7)
        for (int i = 0; i < 16; i++) begin
            at_neg();
            preset_bcd_i = {4'(i), 4'(i)};
            ld_n_i       = 1'b0;
            #1;
            check((i > 9) ? "R7 blank code" : "R1 digit pattern", seg_n_o, disp(i, i));
            at_neg();
            ld_n_i = 1'b1;
        end

        // Full counting run from 00 through 99 back to 00 (R5, R6, R9)
        at_neg();
        clr_n_i = 1'b0;
        at_neg();
        clr_n_i = 1'b1;
        run_i   = 1'b1;
        for (int n = 1; n <= 100; n++) begin
            edge_settle();
            check((n == 100) ? "R6 wrap 99 to 00" : "R5 count step", seg_n_o, disp((n % 100) / 10, n % 10));
            check_zero("R9 zero flag", (n % 100) == 0);
        end

        // Pause holds (R4)
        at_neg();
        run_i = 1'b0;
        load_value(8'h47);
        repeat (3) edge_settle();
        check("R4 hold while paused", seg_n_o, disp(4, 7));
        at_neg();
        run_i = 1'b1;
        edge_settle();
        check("R5 resume after hold", seg_n_o, disp(4, 8));

        // Load held with changing preset (R3)
        at_neg();
        preset_bcd_i = 8'h12;
        ld_n_i       = 1'b0;
        #1;
        check("R3 async load", seg_n_o, disp(1, 2));
        edge_settle();
        check("R3 no count while load held", seg_n_o, disp(1, 2));
        at_neg();
        preset_bcd_i = 8'h34;
        edge_settle();
        check("R3 reload on edge", seg_n_o, disp(3, 4));
        at_neg();
        ld_n_i = 1'b1;
        edge_settle();
        check("R5 count after load", seg_n_o, disp(3, 5));

        // Clear over load and run (R2)
        at_neg();
        preset_bcd_i = 8'h55;
        ld_n_i       = 1'b0;
        clr_n_i      = 1'b0;
        #1;
        check("R2 clear beats load", seg_n_o, disp(0, 0));
        edge_settle();
        check("R2 clear held over edge", seg_n_o, disp(0, 0));
        check_zero("R9 zero under clear", 1'b1);
        at_neg();
        clr_n_i = 1'b1;
        edge_settle();
        check("R3 load after clear release", seg_n_o, disp(5, 5));
        check_zero("R9 nonzero value", 1'b0);
        at_neg();
        ld_n_i = 1'b1;

        // Invalid units code clamps without carry (R8)
        load_value(8'h9C);
        check("R8 invalid units loaded", seg_n_o, disp(9, 12));
        edge_settle();
        check("R8 units clamp no carry", seg_n_o, disp(9, 0));

        // Invalid tens stays until a carry, then clamps (R8)
        load_value(8'hB5);
        edge_settle();
        check("R8 invalid tens kept", seg_n_o, disp(11, 6));
        load_value(8'hB9);
        edge_settle();
        check("R8 tens clamp on carry", seg_n_o, disp(0, 0));
        check_zero("R9 zero after clamp", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule